// File: doc/BRIEF.md
# Parallel Port Mailbox and Data Select Interface

This block is the device-side end of a host parallel port link for a two-channel sampling instrument. The host drives four active-low control lines and the eight data lines. Two of the control lines choose which byte the device places on the data lines: a sample byte from channel A, a sample byte from channel B, the contents of a one-byte mailbox, or a fixed identification byte. The host uses the identification byte to detect the device.

A third control line hands the data bus to the host so that it can write the mailbox. The fourth line is a strobe. Its rising edge either writes the mailbox or tells the sample memory to step to the next byte of the selected channel.

The mailbox is half duplex. A byte written by one side reads as zero from that side until the other side answers, so zero cannot be used as a message value. On the device side, two flags tell the sequencer whether a host byte is waiting and whether its own reply is still unanswered. In scroll mode the channel selections show the live converter outputs instead of the stored samples. All host lines pass through two-flop synchronizers. The output byte is registered.

Top module: `pp_mbox_port`

## Requirements
- R1: The byte on `pp_data_o` is set by `pp_afd_n` and `pp_sel_n` (both active low). With both high it is channel A. With `pp_afd_n` low alone it is channel B. With `pp_sel_n` low alone it is the host view of the mailbox. With both low it is the identification byte 0x55.
- R2: `pp_data_oe` is high while `pp_init_n` is high and low while `pp_init_n` is low. The device releases the bus whenever the host is writing.
- R3: A rising edge of `pp_stb_n` while `pp_init_n` and `pp_sel_n` are both low stores `pp_data_i` in the mailbox. From then on the host reads 0 from the mailbox until the device writes.
- R4: After a host write, `mbox_full` is 1 and `dev_rd_data` shows the host byte. A device write (`dev_wr_en` high for one cycle) does four things: it stores `dev_wr_data`, clears `mbox_full`, sets `reply_pending` and makes `dev_rd_data` read 0. The host then reads the device byte from the mailbox.
- R5: After reset both mailbox views read 0 and both flags are 0. A written value of 0 cannot be told apart from no data by the reader, although the flags still change.
- R6: Each rising edge of `pp_stb_n` with `pp_init_n` high and `pp_sel_n` high gives exactly one single-cycle pulse. The pulse appears on `adv_a` when `pp_afd_n` is high and on `adv_b` when it is low.
- R7: A strobe edge with the mailbox or identification byte selected, or with `pp_init_n` low, gives no advance pulse. A strobe edge with `pp_init_n` high does not change the mailbox.
- R8: While `live_mode` is 1, the channel A and channel B selections show `adc_a` and `adc_b`. While it is 0 they show `buf_a` and `buf_b`.
- R9: A control-line change appears on `pp_data_o` three clock edges after it is applied, which is 24 ns at 125 MHz and within the 200 ns settling budget.
- R10: If a host write and a device write land on the same cycle, the host byte is kept and the device write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst | input | 1 | Synchronous active-high reset |
| pp_stb_n | input | 1 | Host strobe, active low |
| pp_afd_n | input | 1 | Host channel-B select, active low |
| pp_sel_n | input | 1 | Host mailbox select, active low |
| pp_init_n | input | 1 | Host write request, active low |
| pp_data_i | input | 8 | Data lines as driven by the host |
| pp_data_o | output | 8 | Byte the device drives |
| pp_data_oe | output | 1 | Device drive enable for the data lines |
| buf_a | input | 8 | Stored sample byte, channel A |
| buf_b | input | 8 | Stored sample byte, channel B |
| adc_a | input | 8 | Live converter byte, channel A |
| adc_b | input | 8 | Live converter byte, channel B |
| live_mode | input | 1 | Scroll mode: show live values |
| adv_a | output | 1 | One-cycle pulse: next sample, channel A |
| adv_b | output | 1 | One-cycle pulse: next sample, channel B |
| dev_wr_en | input | 1 | Device mailbox write |
| dev_wr_data | input | 8 | Device mailbox byte |
| dev_rd_data | output | 8 | Device view of the mailbox |
| mbox_full | output | 1 | Host byte waiting for the device |
| reply_pending | output | 1 | Device byte not yet answered by the host |

## Verification
The assertions assume that the host holds `pp_sel_n`, `pp_afd_n`, `pp_init_n` and `pp_data_i` steady around every strobe edge, so that the synchronized control and data stages agree when the edge is seen. The stimulus follows this rule. It changes a select or data line only while the strobe is high, and it waits several cycles before and after each strobe pulse. Each strobe low and high phase lasts at least three cycles, so that every edge passes through the synchronizers. To force the same-cycle collision, the device write is placed exactly on the cycle in which the synchronized strobe edge reaches the mailbox.

// File: rtl/pp_port_pkg.sv
package pp_port_pkg;

    // Byte source chosen by the two select lines
    typedef enum logic [1:0] {
        SRC_CHAN_A,
        SRC_CHAN_B,
        SRC_MAILBOX,
        SRC_IDENT
    } src_e;

    // Who wrote the mailbox last
    typedef enum logic [1:0] {
        MB_IDLE,
        MB_FROM_HOST,
        MB_FROM_DEV
    } mb_owner_e;

    // Synchronized control lines, all active low
    typedef struct packed {
        logic stb_n;
        logic afd_n;
        logic sel_n;
        logic init_n;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);
    localparam logic [CTL_W-1:0] CTL_IDLE = '1;

    function automatic src_e decode_src(input logic afd_n, input logic sel_n);
        unique case ({afd_n, sel_n})
            2'b11:   return SRC_CHAN_A;
            2'b01:   return SRC_CHAN_B;
            2'b10:   return SRC_MAILBOX;
            default: return SRC_IDENT;
        endcase
    endfunction

endpackage

// File: rtl/pp_sync.sv
module pp_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= RST_VAL;
                else     stg[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= RST_VAL;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pp_strobe_edge.sv
module pp_strobe_edge
    import pp_port_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ctl_t ctl_s,
    output logic host_wr,
    output logic adv_a,
    output logic adv_b
);
    logic stb_prev;
    logic stb_rise;
    logic chan_sel;

    always_ff @(posedge clk) begin
        if (rst) stb_prev <= 1'b1;
        else     stb_prev <= ctl_s.stb_n;
    end

    assign stb_rise = ctl_s.stb_n & ~stb_prev;
    assign chan_sel = ctl_s.init_n & ctl_s.sel_n;
    assign host_wr  = stb_rise & ~ctl_s.init_n & ~ctl_s.sel_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            adv_a <= 1'b0;
            adv_b <= 1'b0;
        end else begin
            adv_a <= stb_rise & chan_sel &  ctl_s.afd_n;
            adv_b <= stb_rise & chan_sel & ~ctl_s.afd_n;
        end
    end

    p_adv_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
        !(adv_a && adv_b));
    p_adv_a_single_r6: assert property (@(posedge clk) disable iff (rst)
        adv_a |=> !adv_a);
    p_adv_b_single_r6: assert property (@(posedge clk) disable iff (rst)
        adv_b |=> !adv_b);
    p_no_adv_on_write_r7: assert property (@(posedge clk) disable iff (rst)
        host_wr |=> (!adv_a && !adv_b));
endmodule

// File: rtl/pp_mailbox.sv
module pp_mailbox
    import pp_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         host_wr,
    input  logic [W-1:0] host_data,
    input  logic         dev_wr,
    input  logic [W-1:0] dev_data,
    output logic [W-1:0] host_view,
    output logic [W-1:0] dev_view,
    output logic         mbox_full,
    output logic         reply_pending
);
    logic [W-1:0] byte_q;
    mb_owner_e    owner_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_q  <= '0;
            owner_q <= MB_IDLE;
        end else if (host_wr) begin
            byte_q  <= host_data;
            owner_q <= MB_FROM_HOST;
        end else if (dev_wr) begin
            byte_q  <= dev_data;
            owner_q <= MB_FROM_DEV;
        end
    end

    assign host_view     = (owner_q == MB_FROM_DEV)  ? byte_q : '0;
    assign dev_view      = (owner_q == MB_FROM_HOST) ? byte_q : '0;
    assign mbox_full     = (owner_q == MB_FROM_HOST);
    assign reply_pending = (owner_q == MB_FROM_DEV);

    p_host_reads_zero_r3: assert property (@(posedge clk) disable iff (rst)
        host_wr |=> (host_view == '0 && mbox_full));
    p_dev_reads_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (dev_wr && !host_wr) |=> (dev_view == '0 && reply_pending && !mbox_full));
    p_host_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (host_wr && dev_wr) |=> (dev_view == $past(host_data) && !reply_pending));
    p_flags_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mbox_full, reply_pending}));
endmodule

// File: rtl/pp_bus_mux.sv
module pp_bus_mux
    import pp_port_pkg::*;
#(
    parameter int W = 8,
    parameter logic [W-1:0] ID_VALUE = 8'h55
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         afd_n,
    input  logic         sel_n,
    input  logic         init_n,
    input  logic         live_mode,
    input  logic [W-1:0] buf_a,
    input  logic [W-1:0] buf_b,
    input  logic [W-1:0] adc_a,
    input  logic [W-1:0] adc_b,
    input  logic [W-1:0] mbox_view,
    output logic [W-1:0] data_o,
    output logic         data_oe
);
    src_e         src;
    logic [W-1:0] pick;

    assign src = decode_src(afd_n, sel_n);

    always_comb begin
        unique case (src)
            SRC_CHAN_A:  pick = live_mode ? adc_a : buf_a;
            SRC_CHAN_B:  pick = live_mode ? adc_b : buf_b;
            SRC_MAILBOX: pick = mbox_view;
            default:     pick = ID_VALUE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_o  <= '0;
            data_oe <= 1'b0;
        end else begin
            data_o  <= pick;
            data_oe <= init_n;
        end
    end

    p_ident_byte_r1: assert property (@(posedge clk) disable iff (rst)
        (!afd_n && !sel_n) |=> (data_o == ID_VALUE));
    p_release_bus_r2: assert property (@(posedge clk) disable iff (rst)
        !init_n |=> !data_oe);
endmodule

// File: rtl/pp_mbox_port.sv
module pp_mbox_port
    import pp_port_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] ID_VALUE = 8'h55
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pp_stb_n,
    input  logic              pp_afd_n,
    input  logic              pp_sel_n,
    input  logic              pp_init_n,
    input  logic [DATA_W-1:0] pp_data_i,
    output logic [DATA_W-1:0] pp_data_o,
    output logic              pp_data_oe,
    input  logic [DATA_W-1:0] buf_a,
    input  logic [DATA_W-1:0] buf_b,
    input  logic [DATA_W-1:0] adc_a,
    input  logic [DATA_W-1:0] adc_b,
    input  logic              live_mode,
    output logic              adv_a,
    output logic              adv_b,
    input  logic              dev_wr_en,
    input  logic [DATA_W-1:0] dev_wr_data,
    output logic [DATA_W-1:0] dev_rd_data,
    output logic              mbox_full,
    output logic              reply_pending
);
    localparam int SYNC_W = CTL_W + DATA_W;
    localparam logic [SYNC_W-1:0] SYNC_RST = {CTL_IDLE, {DATA_W{1'b0}}};

    ctl_t              ctl_raw;
    ctl_t              ctl_s;
    logic [DATA_W-1:0] data_s;
    logic [SYNC_W-1:0] sync_q;
    logic              host_wr;
    logic [DATA_W-1:0] host_view;

    assign ctl_raw = '{stb_n: pp_stb_n, afd_n: pp_afd_n,
                       sel_n: pp_sel_n, init_n: pp_init_n};

    pp_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ctl_raw, pp_data_i}),
        .q   (sync_q)
    );

    assign ctl_s  = sync_q[SYNC_W-1 -: CTL_W];
    assign data_s = sync_q[DATA_W-1:0];

    pp_strobe_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .ctl_s   (ctl_s),
        .host_wr (host_wr),
        .adv_a   (adv_a),
        .adv_b   (adv_b)
    );

    pp_mailbox #(.W(DATA_W)) u_mbox (
        .clk           (clk),
        .rst           (rst),
        .host_wr       (host_wr),
        .host_data     (data_s),
        .dev_wr        (dev_wr_en),
        .dev_data      (dev_wr_data),
        .host_view     (host_view),
        .dev_view      (dev_rd_data),
        .mbox_full     (mbox_full),
        .reply_pending (reply_pending)
    );

    pp_bus_mux #(.W(DATA_W), .ID_VALUE(ID_VALUE)) u_mux (
        .clk       (clk),
        .rst       (rst),
        .afd_n     (ctl_s.afd_n),
        .sel_n     (ctl_s.sel_n),
        .init_n    (ctl_s.init_n),
        .live_mode (live_mode),
        .buf_a     (buf_a),
        .buf_b     (buf_b),
        .adc_a     (adc_a),
        .adc_b     (adc_b),
        .mbox_view (host_view),
        .data_o    (pp_data_o),
        .data_oe   (pp_data_oe)
    );
endmodule

// File: tb/pp_mbox_port_tb.sv
module pp_mbox_port_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pp_stb_n = 1'b1, pp_afd_n = 1'b1, pp_sel_n = 1'b1, pp_init_n = 1'b1;
    logic [7:0] pp_data_i = 8'h00;
    logic [7:0] pp_data_o;
    logic       pp_data_oe;
    logic [7:0] buf_a = 8'h00, buf_b = 8'h00, adc_a = 8'h00, adc_b = 8'h00;
    logic       live_mode = 1'b0;
    logic       adv_a, adv_b;
    logic       dev_wr_en = 1'b0;
    logic [7:0] dev_wr_data = 8'h00;
    logic [7:0] dev_rd_data;
    logic       mbox_full, reply_pending;

    int total = 0;
    int bad = 0;
    int cnt_a = 0;
    int cnt_b = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pp_mbox_port u_dut (
        .clk(clk), .rst(rst),
        .pp_stb_n(pp_stb_n), .pp_afd_n(pp_afd_n), .pp_sel_n(pp_sel_n), .pp_init_n(pp_init_n),
        .pp_data_i(pp_data_i), .pp_data_o(pp_data_o), .pp_data_oe(pp_data_oe),
        .buf_a(buf_a), .buf_b(buf_b), .adc_a(adc_a), .adc_b(adc_b), .live_mode(live_mode),
        .adv_a(adv_a), .adv_b(adv_b),
        .dev_wr_en(dev_wr_en), .dev_wr_data(dev_wr_data), .dev_rd_data(dev_rd_data),
        .mbox_full(mbox_full), .reply_pending(reply_pending)
    );

    always @(posedge clk) begin
        if (!rst) begin
            if (adv_a) cnt_a <= cnt_a + 1;
            if (adv_b) cnt_b <= cnt_b + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_ctl(input logic afd, input logic sel, input logic init);
        @(negedge clk);
        pp_afd_n = afd; pp_sel_n = sel; pp_init_n = init;
        wait_n(5);
    endtask

    task automatic strobe_pulse();
        @(negedge clk); pp_stb_n = 1'b0;
        wait_n(3);
        pp_stb_n = 1'b1;
        wait_n(5);
    endtask

    task automatic host_write(input logic [7:0] v, input bit collide, input logic [7:0] dv);
        @(negedge clk);
        pp_init_n = 1'b0; pp_sel_n = 1'b0; pp_afd_n = 1'b1; pp_data_i = v;
        wait_n(3);
        pp_stb_n = 1'b0;
        wait_n(3);
        pp_stb_n = 1'b1;
        if (collide) begin
            wait_n(2);
            dev_wr_data = dv; dev_wr_en = 1'b1;
            wait_n(1);
            dev_wr_en = 1'b0;
        end
        wait_n(5);
        pp_init_n = 1'b1;
        wait_n(5);
    endtask

    task automatic dev_write(input logic [7:0] v);
        @(negedge clk);
        dev_wr_data = v; dev_wr_en = 1'b1;
        @(negedge clk);
        dev_wr_en = 1'b0;
        wait_n(2);
    endtask

    task automatic host_read_mbox(output logic [7:0] v);
        set_ctl(1'b1, 1'b0, 1'b1);
        v = pp_data_o;
    endtask

    task automatic t_reset();
        check("R5 full after reset", int'(mbox_full), 0);
        check("R5 pending after reset", int'(reply_pending), 0);
        check("R5 dev view after reset", int'(dev_rd_data), 0);
        check("R2 oe with init high", int'(pp_data_oe), 1);
    endtask

    task automatic t_decode();
        buf_a = 8'hA1; buf_b = 8'hB2;
        set_ctl(1'b1, 1'b1, 1'b1);
        check("R1 channel A", int'(pp_data_o), 'hA1);
        set_ctl(1'b0, 1'b1, 1'b1);
        check("R1 channel B", int'(pp_data_o), 'hB2);
        set_ctl(1'b0, 1'b0, 1'b1);
        check("R1 ident byte", int'(pp_data_o), 'h55);
        set_ctl(1'b1, 1'b0, 1'b1);
        check("R1 empty mailbox", int'(pp_data_o), 0);
    endtask

    task automatic t_latency();
        set_ctl(1'b1, 1'b1, 1'b1);
        @(negedge clk); pp_afd_n = 1'b0;
        wait_n(2);
        check("R9 not yet after two edges", int'(pp_data_o), 'hA1);
        wait_n(1);
        check("R9 shown after three edges", int'(pp_data_o), 'hB2);
    endtask

    task automatic t_init();
        set_ctl(1'b1, 1'b1, 1'b0);
        check("R2 released when init low", int'(pp_data_oe), 0);
        set_ctl(1'b1, 1'b1, 1'b1);
        check("R2 driven again", int'(pp_data_oe), 1);
    endtask

    task automatic t_host_write();
        logic [7:0] r;
        int a0 = cnt_a, b0 = cnt_b;
        host_write(8'h3C, 1'b0, 8'h00);
        check("R4 full after host write", int'(mbox_full), 1);
        check("R4 device sees host byte", int'(dev_rd_data), 'h3C);
        check("R7 no advance on mailbox write", cnt_a + cnt_b, a0 + b0);
        host_read_mbox(r);
        check("R3 host reads zero after own write", int'(r), 0);
    endtask

    task automatic t_dev_reply();
        logic [7:0] r;
        dev_write(8'hA5);
        check("R4 device reads zero after reply", int'(dev_rd_data), 0);
        check("R4 reply pending", int'(reply_pending), 1);
        check("R4 full cleared", int'(mbox_full), 0);
        host_read_mbox(r);
        check("R4 host sees device byte", int'(r), 'hA5);
    endtask

    task automatic t_advance();
        int a0, b0;
        set_ctl(1'b1, 1'b1, 1'b1);
        a0 = cnt_a; b0 = cnt_b;
        for (int i = 0; i < 5; i++) strobe_pulse();
        check("R6 five advances on A", cnt_a - a0, 5);
        check("R6 none on B", cnt_b - b0, 0);
        set_ctl(1'b0, 1'b1, 1'b1);
        a0 = cnt_a; b0 = cnt_b;
        for (int i = 0; i < 3; i++) strobe_pulse();
        check("R6 three advances on B", cnt_b - b0, 3);
        check("R6 none on A", cnt_a - a0, 0);
    endtask

    task automatic t_no_adv();
        logic [7:0] r;
        int s0;
        set_ctl(1'b1, 1'b0, 1'b1);
        s0 = cnt_a + cnt_b;
        pp_data_i = 8'h66;
        strobe_pulse();
        check("R7 no advance with mailbox selected", cnt_a + cnt_b, s0);
        check("R7 mailbox kept on read strobe", int'(reply_pending), 1);
        host_read_mbox(r);
        check("R7 host still reads device byte", int'(r), 'hA5);
        set_ctl(1'b0, 1'b0, 1'b1);
        strobe_pulse();
        check("R7 no advance with ident selected", cnt_a + cnt_b, s0);
        set_ctl(1'b1, 1'b1, 1'b0);
        strobe_pulse();
        check("R7 no advance with init low", cnt_a + cnt_b, s0);
        check("R7 no write with sel high", int'(reply_pending), 1);
        set_ctl(1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_live();
        adc_a = 8'h77; adc_b = 8'h88;
        live_mode = 1'b1;
        set_ctl(1'b1, 1'b1, 1'b1);
        check("R8 live channel A", int'(pp_data_o), 'h77);
        set_ctl(1'b0, 1'b1, 1'b1);
        check("R8 live channel B", int'(pp_data_o), 'h88);
        live_mode = 1'b0;
        wait_n(3);
        check("R8 stored channel B again", int'(pp_data_o), 'hB2);
    endtask

    task automatic t_collide();
        host_write(8'h11, 1'b1, 8'h22);
        check("R10 host byte kept", int'(dev_rd_data), 'h11);
        check("R10 full set", int'(mbox_full), 1);
        check("R10 device write dropped", int'(reply_pending), 0);
    endtask

    task automatic t_zero();
        dev_write(8'h40);
        host_write(8'h00, 1'b0, 8'h00);
        check("R5 zero byte reads as zero", int'(dev_rd_data), 0);
        check("R5 flag still set for zero", int'(mbox_full), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wait_n(4);
        rst = 1'b0;
        wait_n(5);
        t_reset();
        t_decode();
        t_latency();
        t_init();
        t_host_write();
        t_dev_reply();
        t_advance();
        t_no_adv();
        t_live();
        t_collide();
        t_zero();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule